// File: doc/BRIEF.md
# Severity-Locked Error Capture Register

This block keeps a single log word describing the first hardware error reported by four data-path sources of a cache slice. The sources are the cache data array, the fill buffer, the store buffer and the mesh input. Each source can raise a correctable (single-bit) strobe or an uncorrectable (multi-bit) strobe in any cycle. Each strobe comes with the failing access's address, a 2-bit word index and a non-secure flag. Once something is logged, the word is protected according to its severity. A correctable entry only blocks later correctable errors, and an uncorrectable error may replace it. An uncorrectable entry blocks everything until software clears it.

Software reads the log word and releases it by writing 1 to the flag bit of the logged error type. Every cycle the block also raises a one-cycle interrupt pulse for each severity class that reported an error. The pulse names the source that priority selected, whether or not that error was recorded.

Top module: `errlog_capture`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the log word and the interrupt vector read as all zero.
- R2: Log word layout: word index at [5:4], address at [47:6], non-secure flag at [52], correctable flags at [59:56] (bit 56 mesh, 57 store buffer, 58 fill buffer, 59 data array), uncorrectable flags at [63:60] in the same source order. The other bits are zero. On the inputs, strobe bit 0 is the data array, 1 the fill buffer, 2 the store buffer and 3 the mesh.
- R3: While an uncorrectable error is logged and not being cleared, later errors of either severity leave the log word unchanged.
- R4: An empty log captures a correctable error with its fields. Later correctable errors leave the log unchanged while it is held.
- R5: An uncorrectable error overwrites a logged correctable error, or a correctable error that arrives in the same cycle.
- R6: When several errors of one severity arrive together, the data array wins, then the fill buffer, then the store buffer, then the mesh.
- R7: A write whose bit for the logged flag is 1 clears that flag and unlocks the log. The address fields keep their values. A write with 1 only on other flag bits has no effect.
- R8: An error arriving in the same cycle as a clear of the logged flag is captured.
- R9: A capture from the mesh source records zero in the address, word index and non-secure fields.
- R10: One cycle after error strobes arrive, the interrupt vector (same bit layout as bits [63:56]) shows, for each severity, the priority-selected source, for exactly one cycle. This happens even when the log is locked.
- R11: At most one of the eight flags in the log word is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sbe_strobe | input | 4 | Correctable error strobes, bit 0 data array .. bit 3 mesh |
| mbe_strobe | input | 4 | Uncorrectable error strobes, same order |
| fail_addr | input | ADDR_W (42) | Address bits [47:6] of the failing access |
| fail_word | input | 2 | Word index of the failing access |
| fail_nonsec | input | 1 | Non-secure flag of the failing access |
| clr_wr | input | 1 | Software clear write strobe |
| clr_data | input | 8 | Clear mask in the layout of log bits [63:56] |
| log_word | output | 64 | Captured error word |
| err_irq | output | 8 | One-cycle interrupt pulses, layout of log bits [63:56] |

## Verification
The hardest situations to reach are the ones where a clear and a new error land in the same cycle. The outcome then depends on which flag the clear hits and on the severity that arrives with it. The stimulus table first walks the log into a locked uncorrectable state and then into a locked correctable state. In each case it issues the clear together with a fresh strobe: a mesh uncorrectable error for the first, and a fill-buffer correctable error for the second. It also tries a clear aimed at a flag that is not logged. Mixed-severity, multi-source strobes in one cycle cover the priority and overwrite ordering.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    localparam int NUM_SRC  = 4;
    localparam int ADDR_W   = 42;
    localparam int WORD_W   = 2;
    localparam int LOG_W    = 64;
    localparam int FLAG_W   = 2 * NUM_SRC;
    localparam int MESH_IDX = NUM_SRC - 1;

    // Bit positions inside the log word
    localparam int WORD_LSB = 4;
    localparam int ADDR_LSB = 6;
    localparam int NS_BIT   = 52;
    localparam int SBE_LSB  = 56;
    localparam int MBE_LSB  = SBE_LSB + NUM_SRC;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t           sbe;
        src_vec_t           mbe;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  word;
        logic               ns;
        src_vec_t           irq_sbe;
        src_vec_t           irq_mbe;
    } log_state_t;

    // Source index 0 (data array) sits at the highest bit of each nibble.
    function automatic logic [FLAG_W-1:0] pack_flags(src_vec_t mbe, src_vec_t sbe);
        logic [FLAG_W-1:0] f;
        f = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            f[NUM_SRC-1-i]         = sbe[i];
            f[FLAG_W-1-i]          = mbe[i];
        end
        return f;
    endfunction

    function automatic src_vec_t take_sbe(logic [FLAG_W-1:0] f);
        src_vec_t v;
        for (int i = 0; i < NUM_SRC; i++) v[i] = f[NUM_SRC-1-i];
        return v;
    endfunction

    function automatic src_vec_t take_mbe(logic [FLAG_W-1:0] f);
        src_vec_t v;
        for (int i = 0; i < NUM_SRC; i++) v[i] = f[FLAG_W-1-i];
        return v;
    endfunction

endpackage

// File: rtl/errlog_prio.sv
module errlog_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign any = seen[N];

    // R6: the winner is a single requester, and only when someone requests
    always_comb begin
        p_grant_single_r6: assert ($onehot0(grant));
        p_grant_valid_r6:  assert ((grant & ~req) == '0);
    end
endmodule

// File: rtl/errlog_core.sv
module errlog_core
    import errlog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  src_vec_t           sbe_gnt,
    input  logic               sbe_any,
    input  src_vec_t           mbe_gnt,
    input  logic               mbe_any,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [WORD_W-1:0]  word_i,
    input  logic               ns_i,
    input  logic [FLAG_W-1:0]  clr_mask,
    output logic [LOG_W-1:0]   log_word,
    output logic [FLAG_W-1:0]  irq
);
    log_state_t st_d, st_q;

    src_vec_t clr_sbe, clr_mbe, keep_sbe, keep_mbe;
    logic     clr_hit;
    logic     from_mesh;

    assign clr_sbe = take_sbe(clr_mask);
    assign clr_mbe = take_mbe(clr_mask);
    assign clr_hit = (|(clr_sbe & st_q.sbe)) | (|(clr_mbe & st_q.mbe));

    always_comb begin
        st_d      = st_q;
        keep_sbe  = clr_hit ? '0 : st_q.sbe;
        keep_mbe  = clr_hit ? '0 : st_q.mbe;
        from_mesh = 1'b0;

        st_d.sbe  = keep_sbe;
        st_d.mbe  = keep_mbe;

        if (mbe_any && keep_mbe == '0) begin
            // Uncorrectable capture, replacing any correctable entry
            st_d.mbe  = mbe_gnt;
            st_d.sbe  = '0;
            from_mesh = mbe_gnt[MESH_IDX];
            st_d.addr = from_mesh ? '0 : addr_i;
            st_d.word = from_mesh ? '0 : word_i;
            st_d.ns   = from_mesh ? 1'b0 : ns_i;
        end else if (sbe_any && keep_mbe == '0 && keep_sbe == '0) begin
            st_d.sbe  = sbe_gnt;
            from_mesh = sbe_gnt[MESH_IDX];
            st_d.addr = from_mesh ? '0 : addr_i;
            st_d.word = from_mesh ? '0 : word_i;
            st_d.ns   = from_mesh ? 1'b0 : ns_i;
        end

        st_d.irq_sbe = sbe_gnt;
        st_d.irq_mbe = mbe_gnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        log_word = '0;
        log_word[MBE_LSB+NUM_SRC-1:SBE_LSB] = pack_flags(st_q.mbe, st_q.sbe);
        log_word[NS_BIT]                    = st_q.ns;
        log_word[ADDR_LSB+ADDR_W-1:ADDR_LSB] = st_q.addr;
        log_word[WORD_LSB+WORD_W-1:WORD_LSB] = st_q.word;
    end

    assign irq = pack_flags(st_q.irq_mbe, st_q.irq_sbe);

    p_flags_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.sbe, st_q.mbe}));

    p_mbe_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|st_q.mbe) && !clr_hit) |=> $stable(log_word));

    p_sbe_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|st_q.sbe) && !clr_hit && !mbe_any) |=> $stable(log_word));

    p_mbe_overwrites_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mbe == '0) && mbe_any) |=> (|st_q.mbe) && (st_q.sbe == '0));

    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !mbe_any && !sbe_any) |=> (log_word[LOG_W-1:SBE_LSB] == '0));

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mbe_any && !sbe_any) |=> (irq == '0));

endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
    import errlog_pkg::*;
#(
    parameter int ADDR_BITS = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    sbe_strobe,
    input  logic [NUM_SRC-1:0]    mbe_strobe,
    input  logic [ADDR_BITS-1:0]  fail_addr,
    input  logic [WORD_W-1:0]     fail_word,
    input  logic                  fail_nonsec,
    input  logic                  clr_wr,
    input  logic [FLAG_W-1:0]     clr_data,
    output logic [LOG_W-1:0]      log_word,
    output logic [FLAG_W-1:0]     err_irq
);
    src_vec_t          sbe_gnt, mbe_gnt;
    logic              sbe_any, mbe_any;
    logic [FLAG_W-1:0] clr_mask;

    assign clr_mask = clr_wr ? clr_data : '0;

    errlog_prio #(.N(NUM_SRC)) u_prio_sbe (
        .req   (sbe_strobe),
        .grant (sbe_gnt),
        .any   (sbe_any)
    );

    errlog_prio #(.N(NUM_SRC)) u_prio_mbe (
        .req   (mbe_strobe),
        .grant (mbe_gnt),
        .any   (mbe_any)
    );

    errlog_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sbe_gnt  (sbe_gnt),
        .sbe_any  (sbe_any),
        .mbe_gnt  (mbe_gnt),
        .mbe_any  (mbe_any),
        .addr_i   (fail_addr[ADDR_W-1:0]),
        .word_i   (fail_word),
        .ns_i     (fail_nonsec),
        .clr_mask (clr_mask),
        .log_word (log_word),
        .irq      (err_irq)
    );
endmodule

// File: tb/errlog_capture_tb.sv
module errlog_capture_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  sbe;
        logic [3:0]  mbe;
        logic [41:0] addr;
        logic [1:0]  word;
        logic        ns;
        logic [7:0]  clr;
        logic [7:0]  e_flags;
        logic [41:0] e_addr;
        logic [1:0]  e_word;
        logic        e_ns;
        logic [7:0]  e_irq;
        logic [7:0]  tag;
    } vec_t;

    // Flag byte: 7 data-M, 6 fill-M, 5 store-M, 4 mesh-M, 3 data-S, 2 fill-S, 1 store-S, 0 mesh-S
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 4'b0000, 42'h0,   2'd0, 1'b0, 8'h00, 8'h00, 42'h0,   2'd0, 1'b0, 8'h00, 8'd1},  // R1 idle
        '{4'b0010, 4'b0000, 42'h123, 2'd1, 1'b1, 8'h00, 8'h04, 42'h123, 2'd1, 1'b1, 8'h04, 8'd4},  // R4 capture
        '{4'b0001, 4'b0000, 42'h200, 2'd2, 1'b0, 8'h00, 8'h04, 42'h123, 2'd1, 1'b1, 8'h08, 8'd4},  // R4 hold, R10
        '{4'b0000, 4'b0100, 42'h3AB, 2'd3, 1'b0, 8'h00, 8'h20, 42'h3AB, 2'd3, 1'b0, 8'h20, 8'd5},  // R5
        '{4'b0000, 4'b0001, 42'h111, 2'd0, 1'b1, 8'h00, 8'h20, 42'h3AB, 2'd3, 1'b0, 8'h80, 8'd3},  // R3, R10
        '{4'b1000, 4'b0000, 42'h0,   2'd0, 1'b0, 8'h00, 8'h20, 42'h3AB, 2'd3, 1'b0, 8'h01, 8'd3},  // R3
        '{4'b0000, 4'b0000, 42'h0,   2'd0, 1'b0, 8'h80, 8'h20, 42'h3AB, 2'd3, 1'b0, 8'h00, 8'd7},  // R7 wrong bit
        '{4'b0000, 4'b0000, 42'h0,   2'd0, 1'b0, 8'h20, 8'h00, 42'h3AB, 2'd3, 1'b0, 8'h00, 8'd7},  // R7 clear
        '{4'b1111, 4'b0110, 42'h0F0, 2'd2, 1'b1, 8'h00, 8'h40, 42'h0F0, 2'd2, 1'b1, 8'h48, 8'd6},  // R6, R5, R2
        '{4'b0000, 4'b1000, 42'h555, 2'd1, 1'b1, 8'h40, 8'h10, 42'h0,   2'd0, 1'b0, 8'h10, 8'd9},  // R9, R8
        '{4'b0000, 4'b0000, 42'h0,   2'd0, 1'b0, 8'h10, 8'h00, 42'h0,   2'd0, 1'b0, 8'h00, 8'd7},  // R7
        '{4'b1100, 4'b0000, 42'h077, 2'd1, 1'b0, 8'h00, 8'h02, 42'h077, 2'd1, 1'b0, 8'h02, 8'd6},  // R6
        '{4'b0010, 4'b0000, 42'h088, 2'd3, 1'b1, 8'h02, 8'h04, 42'h088, 2'd3, 1'b1, 8'h04, 8'd8},  // R8
        '{4'b0000, 4'b0000, 42'h0,   2'd0, 1'b0, 8'h00, 8'h04, 42'h088, 2'd3, 1'b1, 8'h00, 8'd10}, // R10 single pulse
        '{4'b0000, 4'b0000, 42'h0,   2'd0, 1'b0, 8'h04, 8'h00, 42'h088, 2'd3, 1'b1, 8'h00, 8'd7}   // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sbe_strobe = '0;
    logic [3:0]  mbe_strobe = '0;
    logic [41:0] fail_addr = '0;
    logic [1:0]  fail_word = '0;
    logic        fail_nonsec = 1'b0;
    logic        clr_wr = 1'b0;
    logic [7:0]  clr_data = '0;
    logic [63:0] log_word;
    logic [7:0]  err_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errlog_capture dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sbe_strobe  (sbe_strobe),
        .mbe_strobe  (mbe_strobe),
        .fail_addr   (fail_addr),
        .fail_word   (fail_word),
        .fail_nonsec (fail_nonsec),
        .clr_wr      (clr_wr),
        .clr_data    (clr_data),
        .log_word    (log_word),
        .err_irq     (err_irq)
    );

    function automatic logic [63:0] mk_word(logic [7:0] f, logic [41:0] a, logic [1:0] w, logic ns);
        return {f, 3'b000, ns, 4'b0000, a, w, 4'b0000};
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] s, logic [3:0] m, logic [41:0] a, logic [1:0] w,
                         logic ns, logic [7:0] c);
        sbe_strobe  = s;
        mbe_strobe  = m;
        fail_addr   = a;
        fail_word   = w;
        fail_nonsec = ns;
        clr_wr      = (c != 8'h00);
        clr_data    = c;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk("R1", "log in reset", log_word, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "log after reset", log_word, 64'h0);
        chk("R1", "irq after reset", {56'h0, err_irq}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].sbe, VECS[i].mbe, VECS[i].addr, VECS[i].word, VECS[i].ns, VECS[i].clr);
            @(negedge clk);
            chk($sformatf("R%0d", VECS[i].tag), $sformatf("log v%0d", i), log_word,
                mk_word(VECS[i].e_flags, VECS[i].e_addr, VECS[i].e_word, VECS[i].e_ns));
            chk($sformatf("R%0d", VECS[i].tag), $sformatf("irq v%0d", i),
                {56'h0, err_irq}, {56'h0, VECS[i].e_irq});
            // R11: never more than one flag
            chk("R11", "flag count", 64'($countones(log_word[63:56]) <= 1), 64'd1);
        end

        // R6: among uncorrectable strobes the store buffer beats the mesh
        drive(4'b0000, 4'b1100, 42'h2A, 2'd2, 1'b1, 8'h00);
        @(negedge clk);
        chk("R6", "mbe store over mesh", log_word, mk_word(8'h20, 42'h2A, 2'd2, 1'b1));
        chk("R10", "irq store", {56'h0, err_irq}, 64'h20);

        // R9: correctable mesh capture zeroes the fields
        drive(4'b1000, 4'b0000, 42'h3FF, 2'd3, 1'b1, 8'h20);
        @(negedge clk);
        chk("R9", "mesh sbe fields", log_word, mk_word(8'h01, 42'h0, 2'd0, 1'b0));

        // R1: reset while locked empties the log
        drive(4'b0000, 4'b0001, 42'h1, 2'd1, 1'b1, 8'h00);
        @(negedge clk);
        drive(4'b0000, 4'b0000, 42'h0, 2'd0, 1'b0, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "log after mid reset", log_word, 64'h0);
        chk("R1", "irq after mid reset", {56'h0, err_irq}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        summary();
    end
endmodule